// File: doc/BRIEF.md
# Floppy Controller Glue Logic

This block sits between an 8-bit CPU bus, a floppy disk controller and a latched drive-control byte. It decodes a four-byte window inside the CPU's I/O page for the controller. Inside that window it presents the controller's registers in reverse order: the command/status register is at the top address and the data register at the bottom.

The block also shapes the controller's two request lines for the CPU. The completion interrupt reaches the non-maskable interrupt only when an enable line from a parallel port is high at the moment the interrupt rises. The data request sets a port-style edge flag, and that flag, once enabled, joins the fast interrupt.

A byte written to the drive-control latch is decoded into four active-low drive selects, one active-low motor line, a density-select line and two option pins for the controller. The controller and the drives are outside the block. Their pins appear here as plain inputs and outputs.

Top module: `fdc_glue`

## Requirements
- R1: `fdc_cs` is high exactly when `cpu_cs` is high and `cpu_addr` lies in WIN_BASE..WIN_BASE+3 (default 0x0C..0x0F). `fdc_rd`/`fdc_wr` follow `cpu_rd`/`cpu_wr` only inside that window, and are low everywhere else.
- R2: Register order is reversed. The controller register number is 3 minus the offset in the window: offset 3 gives register 0 (command/status), and offset 0 gives register 3 (data).
- R3: `cpu_rdata` carries `fdc_rdata` during a read inside the window. In every other case it reads 0xFF. `fdc_wdata` always carries `cpu_wdata`.
- R4: A rising edge of `fdc_intrq` sampled while `nmi_en` is high sets `nmi` high from the next clock.
- R5: A rising edge of `fdc_intrq` sampled while `nmi_en` is low leaves `nmi` low. Raising `nmi_en` later, while `fdc_intrq` stays high, does not assert `nmi`.
- R6: A falling edge of `fdc_intrq` clears `nmi` on the next clock, whatever the state of `nmi_en`.
- R7: A rising edge of `fdc_drq` sets a request flag, and a `pb_read` pulse clears it. If both happen in the same cycle, the set wins. The flag reaches `firq` only while `cb1_en` is high.
- R8: `firq` is the OR of `sys_firq`, `port_irq_a` and the enabled request flag.
- R9: A `drv_wr` pulse latches `drv_data` on the clock. The latch holds its value while `drv_wr` is low. Bits 3:0 select drives. Among the set bits, only the highest-numbered one drives its `drv_sel_n` bit low; all other select bits stay high. If bits 3:0 are all zero, every select bit is high.
- R10: `motor_n` is the inverse of latched bit 4. `fdc_dden` equals latched bit 5. `fdc_opt` equals latched bits 7:6.
- R11: Reset clears `nmi`, the request flag and the latch. After reset `drv_sel_n`=4'hF, `motor_n`=1, `fdc_dden`=0 and `fdc_opt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | I/O page select |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | Offset within the I/O page |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| fdc_cs | output | 1 | Controller chip select |
| fdc_rd | output | 1 | Controller read strobe |
| fdc_wr | output | 1 | Controller write strobe |
| fdc_reg | output | 2 | Controller register number (reversed) |
| fdc_wdata | output | 8 | Data to the controller |
| fdc_rdata | input | 8 | Data from the controller |
| fdc_intrq | input | 1 | Controller completion interrupt |
| fdc_drq | input | 1 | Controller data request |
| nmi_en | input | 1 | Port control line that gates the NMI |
| cb1_en | input | 1 | Enable for the data-request flag |
| pb_read | input | 1 | Port B data read pulse; clears the flag |
| sys_firq | input | 1 | Existing system fast-interrupt source |
| port_irq_a | input | 1 | Other interrupt output of the parallel port |
| nmi | output | 1 | Non-maskable interrupt to the CPU |
| firq | output | 1 | Fast interrupt to the CPU |
| drv_wr | input | 1 | Drive-control latch write strobe |
| drv_data | input | 8 | Drive-control byte |
| drv_sel_n | output | 4 | Active-low drive selects |
| motor_n | output | 1 | Active-low motor-on |
| fdc_dden | output | 1 | Density select to the controller |
| fdc_opt | output | 2 | Two further controller option pins |

## Verification
The hardest case to reach is an interrupt that rises while the NMI gate is closed. The fault would be an NMI that appears later, once the gate opens while the interrupt is still high. The stimulus holds `fdc_intrq` high, opens `nmi_en` and clocks several more cycles to show that `nmi` stays low. A second hard case is a data-request edge that lands in the same cycle as a port B read. The bench drives both together and checks that the flag survives.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
    localparam int CTL_W     = 8;
    localparam int NUM_SEL   = 4;
    localparam int MOTOR_BIT = 4;
    localparam int DDEN_BIT  = 5;
    localparam int OPT_LSB   = 6;
    localparam int OPT_W     = 2;
    localparam int REG_W     = 2;

    typedef struct packed {
        logic intrq_q;
        logic drq_q;
        logic nmi_q;
        logic flag_q;
    } irq_state_t;

    typedef struct packed {
        logic [CTL_W-1:0] ctl_q;
    } drv_state_t;
endpackage

// File: rtl/fdc_glue_decode.sv
module fdc_glue_decode
    import fdc_glue_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h0C
) (
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        fdc_rdata,
    output logic [7:0]        cpu_rdata,
    output logic              fdc_cs,
    output logic              fdc_rd,
    output logic              fdc_wr,
    output logic [REG_W-1:0]  fdc_reg
);
    localparam int WIN_SIZE = 1 << REG_W;

    logic [ADDR_W-1:0] offset;
    logic              in_win;

    always_comb begin
        offset    = cpu_addr - WIN_BASE;
        in_win    = cpu_cs && (offset < ADDR_W'(WIN_SIZE));
        fdc_cs    = in_win;
        fdc_rd    = in_win && cpu_rd;
        fdc_wr    = in_win && cpu_wr;
        // highest address maps to register 0
        fdc_reg   = ~offset[REG_W-1:0];
        cpu_rdata = (in_win && cpu_rd) ? fdc_rdata : 8'hFF;
    end
endmodule

// File: rtl/fdc_glue_irq.sv
module fdc_glue_irq
    import fdc_glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fdc_intrq,
    input  logic fdc_drq,
    input  logic nmi_en,
    input  logic cb1_en,
    input  logic pb_read,
    input  logic sys_firq,
    input  logic port_irq_a,
    output logic nmi,
    output logic firq
);
    irq_state_t st_d, st_q;
    logic intrq_rise, intrq_fall, drq_rise;

    always_comb begin
        st_d       = st_q;
        intrq_rise = fdc_intrq && !st_q.intrq_q;
        intrq_fall = !fdc_intrq && st_q.intrq_q;
        drq_rise   = fdc_drq && !st_q.drq_q;

        st_d.intrq_q = fdc_intrq;
        st_d.drq_q   = fdc_drq;

        if (intrq_rise && nmi_en)
            st_d.nmi_q = 1'b1;
        else if (intrq_fall)
            st_d.nmi_q = 1'b0;

        if (drq_rise)
            st_d.flag_q = 1'b1;
        else if (pb_read)
            st_d.flag_q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign nmi  = st_q.nmi_q;
    assign firq = sys_firq || port_irq_a || (st_q.flag_q && cb1_en);
endmodule

// File: rtl/fdc_glue_drive.sv
module fdc_glue_drive
    import fdc_glue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_wr,
    input  logic [CTL_W-1:0] drv_data,
    output logic [NUM_SEL-1:0] drv_sel_n,
    output logic             motor_n,
    output logic             fdc_dden,
    output logic [OPT_W-1:0] fdc_opt
);
    drv_state_t st_d, st_q;
    logic [NUM_SEL-1:0] sel_hi;

    always_comb begin
        st_d = st_q;
        if (drv_wr)
            st_d.ctl_q = drv_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // a select bit wins when no higher-numbered select bit is set
    genvar g;
    generate
        for (g = 0; g < NUM_SEL; g++) begin : g_sel
            if (g == NUM_SEL - 1) begin : g_top
                assign sel_hi[g] = st_q.ctl_q[g];
            end else begin : g_low
                assign sel_hi[g] = st_q.ctl_q[g] && (st_q.ctl_q[NUM_SEL-1:g+1] == '0);
            end
            assign drv_sel_n[g] = !sel_hi[g];
        end
    endgenerate

    assign motor_n  = !st_q.ctl_q[MOTOR_BIT];
    assign fdc_dden = st_q.ctl_q[DDEN_BIT];
    assign fdc_opt  = st_q.ctl_q[OPT_LSB +: OPT_W];
endmodule

// File: rtl/fdc_glue.sv
module fdc_glue
    import fdc_glue_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              fdc_cs,
    output logic              fdc_rd,
    output logic              fdc_wr,
    output logic [1:0]        fdc_reg,
    output logic [7:0]        fdc_wdata,
    input  logic [7:0]        fdc_rdata,
    input  logic              fdc_intrq,
    input  logic              fdc_drq,
    input  logic              nmi_en,
    input  logic              cb1_en,
    input  logic              pb_read,
    input  logic              sys_firq,
    input  logic              port_irq_a,
    output logic              nmi,
    output logic              firq,
    input  logic              drv_wr,
    input  logic [7:0]        drv_data,
    output logic [3:0]        drv_sel_n,
    output logic              motor_n,
    output logic              fdc_dden,
    output logic [1:0]        fdc_opt
);
    assign fdc_wdata = cpu_wdata;

    fdc_glue_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .cpu_cs    (cpu_cs),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .fdc_rdata (fdc_rdata),
        .cpu_rdata (cpu_rdata),
        .fdc_cs    (fdc_cs),
        .fdc_rd    (fdc_rd),
        .fdc_wr    (fdc_wr),
        .fdc_reg   (fdc_reg)
    );

    fdc_glue_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fdc_intrq  (fdc_intrq),
        .fdc_drq    (fdc_drq),
        .nmi_en     (nmi_en),
        .cb1_en     (cb1_en),
        .pb_read    (pb_read),
        .sys_firq   (sys_firq),
        .port_irq_a (port_irq_a),
        .nmi        (nmi),
        .firq       (firq)
    );

    fdc_glue_drive u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_wr    (drv_wr),
        .drv_data  (drv_data),
        .drv_sel_n (drv_sel_n),
        .motor_n   (motor_n),
        .fdc_dden  (fdc_dden),
        .fdc_opt   (fdc_opt)
    );
endmodule

// File: rtl/fdc_glue_chk.sv
module fdc_glue_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_cs,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_rdata,
    input logic              fdc_cs,
    input logic              fdc_rd,
    input logic [1:0]        fdc_reg,
    input logic              fdc_intrq,
    input logic              nmi_en,
    input logic              cb1_en,
    input logic              sys_firq,
    input logic              port_irq_a,
    input logic              nmi,
    input logic              firq,
    input logic              drv_wr,
    input logic [7:0]        drv_data,
    input logic [3:0]        drv_sel_n,
    input logic              motor_n
);
    a_r1_cs_needs_page: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_cs |-> cpu_cs);
    a_r1_rd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_rd |-> (fdc_cs && cpu_rd));
    a_r2_base_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_addr == WIN_BASE) |-> (fdc_cs && fdc_reg == 2'd3));
    a_r3_idle_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !fdc_rd |-> (cpu_rdata == 8'hFF));
    a_r4_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fdc_intrq) && nmi_en) |=> nmi);
    a_r5_closed_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && !nmi_en) |=> !nmi);
    a_r6_fall_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fdc_intrq) |=> !nmi);
    a_r7_flag_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!cb1_en && !sys_firq && !port_irq_a) |-> !firq);
    a_r8_or_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_firq || port_irq_a) |-> firq);
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~drv_sel_n));
    a_r10_motor_latch: assert property (@(posedge clk) disable iff (!rst_n)
        drv_wr |=> (motor_n == !$past(drv_data[4])));
endmodule

bind fdc_glue fdc_glue_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .fdc_cs(fdc_cs), .fdc_rd(fdc_rd), .fdc_reg(fdc_reg),
    .fdc_intrq(fdc_intrq), .nmi_en(nmi_en), .cb1_en(cb1_en), .sys_firq(sys_firq),
    .port_irq_a(port_irq_a), .nmi(nmi), .firq(firq), .drv_wr(drv_wr),
    .drv_data(drv_data), .drv_sel_n(drv_sel_n), .motor_n(motor_n)
);

// File: tb/tb_fdc_glue.sv
`timescale 1ns/1ps
module tb_fdc_glue;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_cs, cpu_rd, cpu_wr;
    logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic       fdc_cs, fdc_rd, fdc_wr;
    logic [1:0] fdc_reg;
    logic [7:0] fdc_wdata, fdc_rdata;
    logic       fdc_intrq, fdc_drq, nmi_en, cb1_en, pb_read, sys_firq, port_irq_a;
    logic       nmi, firq, drv_wr;
    logic [7:0] drv_data;
    logic [3:0] drv_sel_n;
    logic       motor_n, fdc_dden;
    logic [1:0] fdc_opt;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    fdc_glue dut (.*);

    // {cs,rd,wr, addr, exp_cs, exp_reg, exp_rd, exp_wr}
    localparam logic [15:0] VEC [8] = '{
        {3'b110, 8'h0C, 1'b1, 2'd3, 1'b1, 1'b0},
        {3'b101, 8'h0D, 1'b1, 2'd2, 1'b0, 1'b1},
        {3'b110, 8'h0E, 1'b1, 2'd1, 1'b1, 1'b0},
        {3'b101, 8'h0F, 1'b1, 2'd0, 1'b0, 1'b1},
        {3'b110, 8'h0B, 1'b0, 2'd0, 1'b0, 1'b0},
        {3'b110, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0},
        {3'b010, 8'h0C, 1'b0, 2'd0, 1'b0, 1'b0},
        {3'b110, 8'h1C, 1'b0, 2'd0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [7:0] b);
        drv_data = b;
        drv_wr   = 1'b1;
        tick();
        drv_wr   = 1'b0;
    endtask

    function automatic logic [3:0] exp_sel(input logic [7:0] b);
        logic [3:0] e = 4'hF;
        for (int k = 0; k < 4; k++)
            if (b[k]) e = 4'hF & ~(4'b1 << k);
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_cs = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0;
        cpu_wdata = 8'h3C; fdc_rdata = 8'h5A; fdc_intrq = 0; fdc_drq = 0;
        nmi_en = 0; cb1_en = 0; pb_read = 0; sys_firq = 0; port_irq_a = 0;
        drv_wr = 0; drv_data = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        chk(nmi == 1'b0, "R11 nmi", nmi, 0);
        chk(firq == 1'b0, "R11 firq", firq, 0);
        chk(drv_sel_n == 4'hF, "R11 drv_sel_n", drv_sel_n, 4'hF);
        chk(motor_n == 1'b1, "R11 motor_n", motor_n, 1);
        chk(fdc_dden == 1'b0 && fdc_opt == 2'd0, "R11 dden/opt", {fdc_dden, fdc_opt}, 0);

        // R1 R2 R3 decode table
        for (int i = 0; i < 8; i++) begin
            {cpu_cs, cpu_rd, cpu_wr} = VEC[i][15:13];
            cpu_addr = VEC[i][12:5];
            #1;
            chk(fdc_cs == VEC[i][4], "R1 fdc_cs", fdc_cs, VEC[i][4]);
            chk(fdc_rd == VEC[i][1] && fdc_wr == VEC[i][0], "R1 strobes",
                {fdc_rd, fdc_wr}, VEC[i][1:0]);
            if (VEC[i][4])
                chk(fdc_reg == VEC[i][3:2], "R2 reg order", fdc_reg, VEC[i][3:2]);
            chk(cpu_rdata == (VEC[i][1] ? 8'h5A : 8'hFF), "R3 rdata", cpu_rdata,
                VEC[i][1] ? 8'h5A : 8'hFF);
            chk(fdc_wdata == 8'h3C, "R3 wdata", fdc_wdata, 8'h3C);
        end
        cpu_cs = 0; cpu_rd = 0; cpu_wr = 0;

        // R4 gated rise, R6 fall with gate closed
        nmi_en = 1; fdc_intrq = 1; tick();
        chk(nmi == 1'b1, "R4 nmi set", nmi, 1);
        nmi_en = 0; fdc_intrq = 0; tick();
        chk(nmi == 1'b0, "R6 nmi release gate low", nmi, 0);

        // R5 rise while gate closed, then gate opens
        fdc_intrq = 1; tick();
        chk(nmi == 1'b0, "R5 nmi blocked", nmi, 0);
        nmi_en = 1; tick(); tick(); tick();
        chk(nmi == 1'b0, "R5 late enable ignored", nmi, 0);
        fdc_intrq = 0; tick();

        // R6 fall with gate open
        fdc_intrq = 1; tick();
        chk(nmi == 1'b1, "R4 nmi set again", nmi, 1);
        tick();
        chk(nmi == 1'b1, "R4 nmi held", nmi, 1);
        fdc_intrq = 0; tick();
        chk(nmi == 1'b0, "R6 nmi release gate high", nmi, 0);
        nmi_en = 0;

        // R7 data-request flag
        fdc_drq = 1; tick();
        chk(firq == 1'b0, "R7 flag masked", firq, 0);
        cb1_en = 1; #1;
        chk(firq == 1'b1, "R7 flag enabled", firq, 1);
        fdc_drq = 0; tick();
        chk(firq == 1'b1, "R7 flag held", firq, 1);
        pb_read = 1; tick(); pb_read = 0;
        chk(firq == 1'b0, "R7 cleared by read", firq, 0);
        fdc_drq = 1; pb_read = 1; tick(); pb_read = 0;
        chk(firq == 1'b1, "R7 set beats clear", firq, 1);
        fdc_drq = 0; pb_read = 1; tick(); pb_read = 0;
        chk(firq == 1'b0, "R7 cleared again", firq, 0);
        cb1_en = 0;

        // R8 other sources
        sys_firq = 1; #1;
        chk(firq == 1'b1, "R8 sys_firq", firq, 1);
        sys_firq = 0; port_irq_a = 1; #1;
        chk(firq == 1'b1, "R8 port_irq_a", firq, 1);
        port_irq_a = 0; #1;
        chk(firq == 1'b0, "R8 idle", firq, 0);

        // R9 R10 every control byte
        for (int b = 0; b < 256; b++) begin
            write_ctl(8'(b));
            chk(drv_sel_n == exp_sel(8'(b)), "R9 select", drv_sel_n, exp_sel(8'(b)));
            chk(motor_n == !b[4], "R10 motor_n", motor_n, !b[4]);
            chk(fdc_dden == b[5], "R10 dden", fdc_dden, b[5]);
            chk(fdc_opt == b[7:6], "R10 opt", fdc_opt, b[7:6]);
        end

        // R9 hold without strobe
        write_ctl(8'h12);
        drv_data = 8'hEF; tick(); tick();
        chk(drv_sel_n == 4'hD, "R9 hold sel", drv_sel_n, 4'hD);
        chk(motor_n == 1'b0, "R9 hold motor", motor_n, 0);

        // R11 reset clears latch and nmi
        nmi_en = 1; fdc_intrq = 1; tick();
        rst_n = 0; tick(); rst_n = 1; #1;
        chk(nmi == 1'b0, "R11 nmi after reset", nmi, 0);
        chk(drv_sel_n == 4'hF && motor_n, "R11 drive after reset", {drv_sel_n, motor_n}, 5'h1F);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule